// File: doc/BRIEF.md
# Challenge-Response Window Watchdog

This block supervises a host microcontroller through register writes that arrive already decoded from a serial link. It offers three ways to service it. In timeout style any refresh before expiry is good. In window style the period is split into a closed first half, where a refresh is an error, and an open second half. In challenge style the refresh must also carry the bit-inverted copy of an 8-bit pseudo-random code that the block publishes. That answer can come as one write or as two nibble writes. The style, the period and the reset-request length sit in a configuration register that can be changed only while the system is in its initialisation phase.

Any failure raises a reset request for a programmable number of ticks and bumps a saturating failure counter. The failures are an expired period, a refresh in the closed half, and a wrong answer. The period and the hold length are measured in ticks of a slow timebase pulse, so the block runs from the fast system clock. While the reset request is high, or while the initialisation phase flag is set, the timer is parked at zero and refresh writes are ignored. Once the request drops, a fresh full period starts.

Top module: `chal_watchdog`

## Requirements
- R1: After synchronous reset `rst_req_o` is 0, `fail_cnt_o` is 0, `code_o` is 8'hA5 and `kind_o` is 2'b01 (window style). The default period select is 1 and the default hold select is 1.
- R2: A write to address 5'b00110 updates the configuration only while `init_mode` is 1. The data fields are kind in bits [1:0], the two-write flag in bit [2], the period select p in bits [5:3] and the hold select h in bits [7:6]. The kind is encoded 00 timeout, 01 window, 10 challenge, and 11 is taken as window. A write to this address while `init_mode` is 0 leaves `kind_o` unchanged.
- R3: The timer starts from zero and advances one step per `tick` only while `init_mode` is 0 and `rst_req_o` is 0. The half period is H = (p+1)*4 ticks. `win_open_o` is 1 in timeout style, or when the timer is at least H.
- R4: With no accepted refresh, the 2H-th counted tick is a failure.
- R5: In window and challenge style, a refresh write (address 5'b01101) while the timer is below H is a failure. In window style a refresh in the open half is accepted and restarts the timer.
- R6: In timeout style a refresh write is accepted at any timer value.
- R7: In challenge style with the two-write flag at 0, a refresh is accepted only if its data equals ~`code_o`. Any other data is a failure.
- R8: In challenge style with the two-write flag at 1, the first refresh write must carry ~`code_o`[7:4] in data[3:0] and the second must carry ~`code_o`[3:0]. A wrong half is a failure. The first half alone changes nothing visible, and expiry with only one half received is a failure.
- R9: Each accepted refresh replaces the code c with {c[6:0], c[7]^c[5]^c[4]^c[3]}. No other event changes the code.
- R10: A failure sets `rst_req_o` on the next clock edge. It stays high for exactly (h+1)*2 ticks, and refresh writes during that time change nothing.
- R11: `fail_cnt_o` increases by one on every failure and saturates at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | System is in its initialisation phase |
| tick | input | 1 | One-cycle timebase pulse |
| wr_stb | input | 1 | Decoded register write strobe |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 8 | Write data |
| rst_req_o | output | 1 | Reset request to the system |
| code_o | output | 8 | Current challenge code for readback |
| fail_cnt_o | output | 2 | Saturating failure count |
| win_open_o | output | 1 | Refresh would land in the open part of the period |
| kind_o | output | 2 | Locked watchdog style |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that a write strobe lasts one cycle per command. They also assume that the configuration is rewritten only while the timer is parked, so the pending-half flag can never outlive a style change. The bench drives every input on the falling edge, one command or tick per cycle, and never overlaps a write with a tick. It changes the configuration only with `init_mode` high. Before leaving initialisation it drains any running reset request with enough ticks, so each trial starts from a parked timer at zero.

// File: rtl/chal_wd_pkg.sv
package chal_wd_pkg;

  typedef enum logic [1:0] {
    WD_TIMEOUT  = 2'b00,
    WD_WINDOW   = 2'b01,
    WD_ADVANCED = 2'b10
  } wd_kind_e;

  typedef struct packed {
    logic [1:0] hold_sel;
    logic [2:0] per_sel;
    logic       two_cmd;
    wd_kind_e   kind;
  } wd_cfg_t;

  localparam logic [4:0] REFRESH_ADDR = 5'b01101;

  function automatic logic [7:0] lfsr_next(input logic [7:0] c);
    return {c[6:0], c[7] ^ c[5] ^ c[4] ^ c[3]};
  endfunction

  function automatic wd_kind_e decode_kind(input logic [1:0] f);
    case (f)
      2'b00:   return WD_TIMEOUT;
      2'b10:   return WD_ADVANCED;
      default: return WD_WINDOW;
    endcase
  endfunction

endpackage

// File: rtl/wd_cfg_reg.sv
module wd_cfg_reg
  import chal_wd_pkg::*;
#(
  parameter logic [4:0] CFG_ADDR  = 5'b00110,
  parameter logic [7:0] RESET_CFG = 8'h49
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init_mode,
  input  logic                wr_stb,
  input  logic [4:0]          wr_addr,
  input  logic [7:0]          wr_data,
  output chal_wd_pkg::wd_cfg_t cfg
);

  logic cfg_we;
  assign cfg_we = wr_stb && init_mode && (wr_addr == CFG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.hold_sel <= RESET_CFG[7:6];
      cfg.per_sel  <= RESET_CFG[5:3];
      cfg.two_cmd  <= RESET_CFG[2];
      cfg.kind     <= decode_kind(RESET_CFG[1:0]);
    end else if (cfg_we) begin
      cfg.hold_sel <= wr_data[7:6];
      cfg.per_sel  <= wr_data[5:3];
      cfg.two_cmd  <= wr_data[2];
      cfg.kind     <= decode_kind(wr_data[1:0]);
    end
  end

  // R2: configuration is frozen whenever the init phase flag is low
  p_cfg_lock_r2: assert property (@(posedge clk) disable iff (rst)
    !init_mode |=> $stable(cfg));

endmodule

// File: rtl/wd_lfsr.sv
module wd_lfsr
  import chal_wd_pkg::*;
#(
  parameter logic [7:0] SEED = 8'hA5  // must be non-zero
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       advance,
  output logic [7:0] code
);

  always_ff @(posedge clk) begin
    if (rst)          code <= SEED;
    else if (advance) code <= lfsr_next(code);
  end

  // R9: code moves only on an accepted refresh
  p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(code));
  // R9: the sequence never falls into the all-zero lock-up state
  p_code_live_r9: assert property (@(posedge clk) disable iff (rst)
    code != 8'h00);

endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
  parameter int UNIT = 4,
  parameter int TW   = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       clear,
  input  logic       tick,
  input  logic       windowed,
  input  logic [2:0] per_sel,
  output logic       open_o,
  output logic       expire_o
);

  logic [TW-1:0] cnt;
  logic [TW-1:0] half_len;
  logic [TW-1:0] last_cnt;

  always_comb begin
    half_len = TW'({1'b0, per_sel} + 4'd1) * TW'(UNIT);
    last_cnt = (half_len << 1) - TW'(1);
    open_o   = !windowed || (cnt >= half_len);
    expire_o = run && tick && (cnt == last_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || clear) cnt <= '0;
    else if (tick)            cnt <= cnt + TW'(1);
  end

  // R3: the count never passes the end of the period
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_cnt);
  // R3: a parked timer reads zero on the following cycle
  p_cnt_park_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);

endmodule

// File: rtl/wd_reset_stretch.sv
module wd_reset_stretch #(
  parameter int HOLD_UNIT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fail,
  input  logic       tick,
  input  logic [1:0] hold_sel,
  output logic       rst_req,
  output logic [1:0] fail_cnt
);

  localparam int HW = $clog2(4 * HOLD_UNIT) + 1;

  logic [HW-1:0] hcnt;
  logic [HW-1:0] hold_len;

  assign hold_len = HW'({1'b0, hold_sel} + 3'd1) * HW'(HOLD_UNIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req  <= 1'b0;
      hcnt     <= '0;
      fail_cnt <= 2'd0;
    end else if (fail) begin
      rst_req <= 1'b1;
      hcnt    <= '0;
      if (fail_cnt != 2'd3) fail_cnt <= fail_cnt + 2'd1;
    end else if (rst_req && tick) begin
      if (hcnt == hold_len - HW'(1)) rst_req <= 1'b0;
      else                           hcnt    <= hcnt + HW'(1);
    end
  end

  // R10: the request only ends on a tick
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    rst_req && !tick |=> rst_req);
  // R10: no new failure can be raised while the request is active
  p_no_fail_in_hold_r10: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !fail);
  // R11: saturated count stays saturated
  p_sat_r11: assert property (@(posedge clk) disable iff (rst)
    fail_cnt == 2'd3 |=> fail_cnt == 2'd3);
  // R11: the count never goes down
  p_mono_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fail_cnt >= $past(fail_cnt));

endmodule

// File: rtl/chal_watchdog.sv
module chal_watchdog
  import chal_wd_pkg::*;
#(
  parameter int         UNIT      = 4,
  parameter int         HOLD_UNIT = 2,
  parameter logic [7:0] SEED      = 8'hA5,
  parameter logic [4:0] CFG_ADDR  = 5'b00110,
  parameter logic [7:0] RESET_CFG = 8'h49
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       init_mode,
  input  logic       tick,
  input  logic       wr_stb,
  input  logic [4:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       rst_req_o,
  output logic [7:0] code_o,
  output logic [1:0] fail_cnt_o,
  output logic       win_open_o,
  output logic [1:0] kind_o
);

  localparam int TW = $clog2(16 * UNIT) + 1;

  wd_cfg_t    cfg;
  logic [7:0] code;
  logic       run, ref_wr, open_now, expire;
  logic       accept, bad, set_pend, fail, pending;
  logic [7:0] answer;

  wd_cfg_reg #(.CFG_ADDR(CFG_ADDR), .RESET_CFG(RESET_CFG)) u_cfg (
    .clk(clk), .rst(rst), .init_mode(init_mode), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg)
  );

  wd_lfsr #(.SEED(SEED)) u_code (
    .clk(clk), .rst(rst), .advance(accept), .code(code)
  );

  wd_timer #(.UNIT(UNIT), .TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .run(run), .clear(accept || fail), .tick(tick),
    .windowed(cfg.kind != WD_TIMEOUT), .per_sel(cfg.per_sel),
    .open_o(open_now), .expire_o(expire)
  );

  wd_reset_stretch #(.HOLD_UNIT(HOLD_UNIT)) u_hold (
    .clk(clk), .rst(rst), .fail(fail), .tick(tick),
    .hold_sel(cfg.hold_sel), .rst_req(rst_req_o), .fail_cnt(fail_cnt_o)
  );

  assign run    = !init_mode && !rst_req_o;
  assign ref_wr = wr_stb && (wr_addr == REFRESH_ADDR) && run;
  assign answer = ~code;

  // Refresh judgement: closed half first, then style, then answer halves
  always_comb begin
    accept   = 1'b0;
    bad      = 1'b0;
    set_pend = 1'b0;
    if (ref_wr) begin
      if (!open_now) begin
        bad = 1'b1;
      end else if (cfg.kind != WD_ADVANCED) begin
        accept = 1'b1;
      end else if (!cfg.two_cmd) begin
        if (wr_data == answer) accept = 1'b1;
        else                   bad    = 1'b1;
      end else if (!pending) begin
        if (wr_data[3:0] == answer[7:4]) set_pend = 1'b1;
        else                             bad      = 1'b1;
      end else begin
        if (wr_data[3:0] == answer[3:0]) accept = 1'b1;
        else                             bad    = 1'b1;
      end
    end
    fail = bad || (expire && !accept);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || accept || fail) pending <= 1'b0;
    else if (set_pend)                 pending <= 1'b1;
  end

  assign code_o     = code;
  assign win_open_o = open_now;
  assign kind_o     = cfg.kind;

  // R8: a stored upper half only exists in two-write challenge style
  p_pend_mode_r8: assert property (@(posedge clk) disable iff (rst)
    pending |-> (cfg.kind == WD_ADVANCED) && cfg.two_cmd);
  // R5: an accepted refresh never coincides with a failure
  p_acc_excl_r5: assert property (@(posedge clk) disable iff (rst)
    accept |-> !bad);
  // R10: the request rises on the edge after a failure
  p_req_rise_r10: assert property (@(posedge clk) disable iff (rst)
    fail |=> rst_req_o);

endmodule

// File: tb/sim_chal_watchdog.sv
`timescale 1ns/1ps
module sim_chal_watchdog;

  localparam logic [4:0] CFG_A = 5'b00110;
  localparam logic [4:0] REF_A = 5'b01101;
  localparam int         UNITB = 4;
  localparam int         HUNIT = 2;

  logic       clk = 1'b0;
  logic       rst, init_mode, tick, wr_stb;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic       rst_req_o, win_open_o;
  logic [7:0] code_o;
  logic [1:0] fail_cnt_o, kind_o;

  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] exp_code;
  logic [1:0] exp_fail;

  always #4 clk = ~clk;

  chal_watchdog u0 (
    .clk(clk), .rst(rst), .init_mode(init_mode), .tick(tick),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_req_o(rst_req_o), .code_o(code_o), .fail_cnt_o(fail_cnt_o),
    .win_open_o(win_open_o), .kind_o(kind_o)
  );

  function automatic logic [7:0] nxt(input logic [7:0] c);
    return {c[6:0], c[7] ^ c[5] ^ c[4] ^ c[3]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic bump_fail();
    if (exp_fail != 2'd3) exp_fail = exp_fail + 2'd1;
  endtask

  task automatic configure(input logic [1:0] kind, input logic two,
                           input logic [2:0] per, input logic [1:0] hold);
    init_mode = 1'b1;
    @(negedge clk);
    ticks(8);
    wr(CFG_A, {hold, per, two, kind});
    init_mode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; init_mode = 1'b1; tick = 1'b0;
    wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_code = 8'hA5; exp_fail = 2'd0;
    check("R1 rst_req", rst_req_o, 0);
    check("R1 fail_cnt", fail_cnt_o, 0);
    check("R1 code", code_o, 8'hA5);
    check("R1 kind", kind_o, 2'b01);

    // R2: kind 11 decodes to window; lock outside init
    configure(2'b11, 1'b0, 3'd0, 2'd0);
    check("R2 kind 11 as window", kind_o, 2'b01);
    configure(2'b00, 1'b0, 3'd0, 2'd0);
    check("R2 init write", kind_o, 2'b00);
    wr(CFG_A, 8'h01);
    check("R2 locked outside init", kind_o, 2'b00);

    // R5/R6/R3 sweep: refresh at every timer value, timeout and window style
    for (int kd = 0; kd < 2; kd++) begin
      for (int k = 0; k < 2 * UNITB; k++) begin
        configure(kd[1:0], 1'b0, 3'd0, 2'd0);
        ticks(k);
        check("R3 open flag", win_open_o, (kd == 0) || (k >= UNITB));
        wr(REF_A, 8'h00);
        if (kd == 1 && k < UNITB) begin
          bump_fail();
          check("R5 closed refresh fails", rst_req_o, 1);
        end else begin
          exp_code = nxt(exp_code);
          check(kd == 0 ? "R6 refresh accepted" : "R5 open refresh accepted",
                rst_req_o, 0);
        end
        check("R9 code", code_o, exp_code);
        check("R11 count", fail_cnt_o, exp_fail);
      end
    end

    // R4: expiry exactly at 2H ticks for each period select
    for (int p = 0; p < 4; p++) begin
      configure(2'b01, 1'b0, p[2:0], 2'd0);
      ticks(2 * (p + 1) * UNITB - 1);
      check("R4 before expiry", rst_req_o, 0);
      ticks(1);
      bump_fail();
      check("R4 at expiry", rst_req_o, 1);
      check("R11 count", fail_cnt_o, exp_fail);
    end

    // R10: hold length with h=2 is 6 ticks; refresh during hold ignored
    configure(2'b00, 1'b0, 3'd0, 2'd2);
    ticks(2 * UNITB);
    bump_fail();
    check("R10 raised", rst_req_o, 1);
    ticks(3 * HUNIT - 1);
    wr(REF_A, 8'h00);
    check("R10 still held", rst_req_o, 1);
    check("R10 refresh ignored code", code_o, exp_code);
    ticks(1);
    check("R10 released", rst_req_o, 0);
    ticks(2 * UNITB - 1);
    check("R3 fresh period after hold", rst_req_o, 0);
    ticks(1);
    bump_fail();
    check("R3 expiry after hold", rst_req_o, 1);
    check("R11 saturated", fail_cnt_o, exp_fail);

    // R7: single-write challenge
    configure(2'b10, 1'b0, 3'd0, 2'd0);
    ticks(UNITB);
    wr(REF_A, ~exp_code);
    exp_code = nxt(exp_code);
    check("R7 good answer", rst_req_o, 0);
    check("R9 code after good answer", code_o, exp_code);
    ticks(UNITB);
    wr(REF_A, ~exp_code ^ 8'h10);
    check("R7 wrong answer", rst_req_o, 1);
    check("R9 code unchanged on wrong", code_o, exp_code);
    configure(2'b10, 1'b0, 3'd0, 2'd0);
    ticks(2);
    wr(REF_A, ~exp_code);
    check("R5 early good answer fails", rst_req_o, 1);
    check("R9 code unchanged early", code_o, exp_code);

    // R8: two-write challenge
    configure(2'b10, 1'b1, 3'd0, 2'd0);
    ticks(UNITB);
    wr(REF_A, {4'h0, ~exp_code[7:4]});
    check("R8 first half silent", rst_req_o, 0);
    check("R8 code kept after first half", code_o, exp_code);
    wr(REF_A, {4'h0, ~exp_code[3:0]});
    exp_code = nxt(exp_code);
    check("R8 both halves accepted", rst_req_o, 0);
    check("R8 code advanced", code_o, exp_code);
    ticks(UNITB);
    wr(REF_A, {4'h0, exp_code[7:4]});
    check("R8 wrong upper half", rst_req_o, 1);
    configure(2'b10, 1'b1, 3'd0, 2'd0);
    ticks(UNITB);
    wr(REF_A, {4'h0, ~exp_code[7:4]});
    wr(REF_A, {4'h0, exp_code[3:0]});
    check("R8 wrong lower half", rst_req_o, 1);
    configure(2'b10, 1'b1, 3'd0, 2'd0);
    ticks(UNITB);
    wr(REF_A, {4'h0, ~exp_code[7:4]});
    ticks(UNITB - 1);
    check("R8 pending before expiry", rst_req_o, 0);
    ticks(1);
    check("R8 half answer expires", rst_req_o, 1);
    check("R9 code after partial", code_o, exp_code);
    check("R11 final count", fail_cnt_o, 2'd3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule